// File: doc/BRIEF.md
# NAND Strobe Timing Generator

This block shapes one NAND bus access at a time. It takes a packed timing word that holds seven cycle counts, and a request that names the direction of the access. From these it drives the active-low chip enable, read enable and write enable. Every phase is counted in controller clock cycles: an optional turnaround gap with chip enable still high, a chip-enable setup interval, the strobe low time, and the strobe high time. A write also gets a settling delay, and after that the block waits on the ready/busy pin. A one-cycle done pulse closes each access.

The surrounding controller presents a request while the block is idle. The block takes a copy of the timing word in the same cycle, so the word may change at any time afterwards. Command and address sequencing, and the data path, belong to other blocks.

Top module: `nand_strobe_timer`

## Requirements
- R1: After reset, and whenever no access is running, ce_n, re_n and we_n are 1 and cycle_done is 0. A reset in the middle of an access returns the block to this state and clears the direction history.
- R2: The timing word is split into fields by bit position. Write-low is bits 3:0, write-high is bits 7:4, read-low is bits 11:8, read-high is bits 15:12, turnaround is bits 18:16, busy delay is bits 23:19, and chip-enable setup is bits 25:24. Bits above 25 have no effect. The word is captured when a request is accepted, and later changes do not affect that access.
- R3: A request is accepted at a clock edge where req_valid is 1 and the block is idle. The first phase of the access begins in the next cycle.
- R4: The strobe named by req_write is driven low: 1 selects we_n and 0 selects re_n. It stays low for the matching low field in cycles, with a minimum of one cycle when the field is 0. The other strobe stays 1 for the whole access.
- R5: After the strobe rises, the strobe-high phase lasts the matching high field in cycles, with a minimum of one cycle, and ce_n stays 0 throughout.
- R6: ce_n falls before the strobe by the setup field in cycles, with both strobes at 1 during that interval. When the field is 0, the strobe falls in the same cycle as ce_n.
- R7: Before the setup interval, a gap of turnaround-field cycles with ce_n still 1 is inserted when the direction differs from the previous access accepted since reset. There is no gap for the first access after reset or when the direction is unchanged.
- R8: After the strobe-high phase of a write, busy-delay-field cycles pass during which rb_n is ignored. After that, rb_n is sampled once per cycle until it reads 1 (ready).
- R9: cycle_done is 1 for exactly one cycle, and ce_n is 1 in that cycle. For a read it comes in the cycle after the strobe-high phase. For a write it comes in the cycle after the edge at which rb_n was sampled as 1.
- R10: req_valid has no effect while an access is running, including its done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous reset, active low |
| timing_word | input | TW_W | Packed cycle counts |
| req_valid | input | 1 | Request to start an access |
| req_write | input | 1 | Direction of the request: 1 write, 0 read |
| rb_n | input | 1 | Ready/busy pin, 1 when ready, synchronous to clk |
| ce_n | output | 1 | Chip enable, active low |
| re_n | output | 1 | Read enable strobe, active low |
| we_n | output | 1 | Write enable strobe, active low |
| cycle_done | output | 1 | One-cycle pulse at the end of an access |

## Verification
Two events can fall in the same cycle here. A fresh request can arrive in the cycle where the running access pulses cycle_done, and a request can also arrive in the middle of a running access. The bench raises req_valid with the opposite direction at both moments. It then judges that the done cycle is unmoved, that only one done pulse appears, and that ce_n stays high in the idle cycles that follow. The other overlap is rb_n reading ready while the busy delay is still counting. This is judged by the done cycle, which must come only after the delay has fully expired.

// File: rtl/nst_pkg.sv
// Shared types for the NAND strobe timing generator.
// Assumes the timing word carries its fields in the bit positions listed below.
package nst_pkg;

    localparam int FIELD_BITS = 26;
    localparam int CNT_W      = 5;

    // Field order follows the bit positions of the timing word, MSB first.
    typedef struct packed {
        logic [1:0] ce_setup;
        logic [4:0] busy_dly;
        logic [2:0] turn;
        logic [3:0] rd_hi;
        logic [3:0] rd_lo;
        logic [3:0] wr_hi;
        logic [3:0] wr_lo;
    } tfields_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_SETUP,
        PH_LOW,
        PH_HIGH,
        PH_BDLY,
        PH_RBW,
        PH_DONE
    } phase_e;

    // Strobe phases never shrink below one cycle.
    function automatic logic [CNT_W-1:0] at_least_one(input logic [3:0] v);
        return (v == 4'd0) ? CNT_W'(1) : CNT_W'(v);
    endfunction

endpackage

// File: rtl/nst_phase_timer.sv
// Down counter that times one bus phase.
// Loading writes the phase length minus one. expired is high while the count is zero.
// Assumes the load value fits in W bits.
module nst_phase_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt;

    // Load on a phase change, otherwise count down to zero and hold there.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R5
    tmr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> (cnt == '0));

endmodule

// File: rtl/nst_turn_tracker.sv
// Remembers the direction of the last accepted access and reports a
// direction change for the request being offered.
// Assumes accept is high for exactly one cycle per access.
module nst_turn_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic req_wr,
    output logic need_gap
);

    logic have_prev;
    logic last_wr;

    // Record the direction of each accepted access. Reset forgets it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_prev <= 1'b0;
            last_wr   <= 1'b0;
        end else if (accept) begin
            have_prev <= 1'b1;
            last_wr   <= req_wr;
        end
    end

    assign need_gap = have_prev && (last_wr != req_wr);

    // R7
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(last_wr));

endmodule

// File: rtl/nand_strobe_timer.sv
// NAND strobe timing generator.
// Runs one access per request through the phases turnaround, chip-enable setup,
// strobe low, strobe high and, for writes, busy delay and wait for ready, then done.
// Assumes rb_n is already synchronous to clk and TW_W is at least 26.
module nand_strobe_timer
    import nst_pkg::*;
#(
    parameter int TW_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [TW_W-1:0] timing_word,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic            rb_n,
    output logic            ce_n,
    output logic            re_n,
    output logic            we_n,
    output logic            cycle_done
);

    phase_e          state, nxt;
    tfields_t        held, live, fsel;
    logic            wr_q, dir, accept, advance, need_gap, expired;
    logic [CNT_W-1:0] len, load_val;
    logic [CNT_W-1:0] low_run;

    assign live   = tfields_t'(timing_word[FIELD_BITS-1:0]);
    assign fsel   = (state == PH_IDLE) ? live : held;
    assign dir    = (state == PH_IDLE) ? req_write : wr_q;
    assign accept = (state == PH_IDLE) && req_valid;

    nst_turn_tracker u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .req_wr   (req_write),
        .need_gap (need_gap)
    );

    nst_phase_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (advance),
        .load_val (load_val),
        .expired  (expired)
    );

    // Pick the next phase, skipping the phases whose count is zero.
    always_comb begin
        advance = 1'b0;
        nxt     = state;
        unique case (state)
            PH_IDLE: if (req_valid) begin
                advance = 1'b1;
                if (need_gap && fsel.turn != '0) nxt = PH_TURN;
                else if (fsel.ce_setup != '0)    nxt = PH_SETUP;
                else                             nxt = PH_LOW;
            end
            PH_TURN: if (expired) begin
                advance = 1'b1;
                nxt     = (fsel.ce_setup != '0) ? PH_SETUP : PH_LOW;
            end
            PH_SETUP: if (expired) begin
                advance = 1'b1;
                nxt     = PH_LOW;
            end
            PH_LOW: if (expired) begin
                advance = 1'b1;
                nxt     = PH_HIGH;
            end
            PH_HIGH: if (expired) begin
                advance = 1'b1;
                if (!dir)                       nxt = PH_DONE;
                else if (fsel.busy_dly != '0)   nxt = PH_BDLY;
                else                            nxt = PH_RBW;
            end
            PH_BDLY: if (expired) begin
                advance = 1'b1;
                nxt     = PH_RBW;
            end
            PH_RBW: if (rb_n) begin
                advance = 1'b1;
                nxt     = PH_DONE;
            end
            PH_DONE: begin
                advance = 1'b1;
                nxt     = PH_IDLE;
            end
            default: begin
                advance = 1'b1;
                nxt     = PH_IDLE;
            end
        endcase
    end

    // Length in cycles of the phase being entered.
    always_comb begin
        unique case (nxt)
            PH_TURN:  len = CNT_W'(fsel.turn);
            PH_SETUP: len = CNT_W'(fsel.ce_setup);
            PH_LOW:   len = dir ? at_least_one(fsel.wr_lo) : at_least_one(fsel.rd_lo);
            PH_HIGH:  len = dir ? at_least_one(fsel.wr_hi) : at_least_one(fsel.rd_hi);
            PH_BDLY:  len = fsel.busy_dly;
            default:  len = CNT_W'(1);
        endcase
    end

    assign load_val = len - 1'b1;

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)       state <= PH_IDLE;
        else if (advance) state <= nxt;
    end

    // Capture the timing word and direction when a request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held <= '0;
            wr_q <= 1'b0;
        end else if (accept) begin
            held <= live;
            wr_q <= req_write;
        end
    end

    // Bus outputs decoded from the registered phase.
    always_comb begin
        ce_n       = !(state inside {PH_SETUP, PH_LOW, PH_HIGH, PH_BDLY, PH_RBW});
        re_n       = !(state == PH_LOW && !wr_q);
        we_n       = !(state == PH_LOW && wr_q);
        cycle_done = (state == PH_DONE);
    end

    // Length of the current strobe-low run, used only by the checks below.
    always_ff @(posedge clk) begin
        if (!rst_n)              low_run <= '0;
        else if (!re_n || !we_n) low_run <= low_run + 1'b1;
        else                     low_run <= '0;
    end

    // R4
    wr_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (low_run == at_least_one(held.wr_lo)));

    // R4
    rd_low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(re_n) |-> (low_run == at_least_one(held.rd_lo)));

    // R6
    strobe_in_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(re_n) || $fell(we_n)) |-> !ce_n);

    // R8
    rb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_done && wr_q) |-> $past(rb_n));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cycle_done |=> (!cycle_done && ce_n));

    // R10
    dir_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != PH_IDLE) |=> $stable(wr_q));

endmodule

// File: tb/tb_nand_strobe_timer.sv
module tb_nand_strobe_timer;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] timing_word;
    logic        req_valid, req_write, rb_n;
    logic        ce_n, re_n, we_n, cycle_done;

    int checks = 0;
    int fails  = 0;
    logic have_prev = 1'b0;
    logic prev_wr   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    nand_strobe_timer #(.TW_W(32)) dut (
        .clk(clk), .rst_n(rst_n), .timing_word(timing_word),
        .req_valid(req_valid), .req_write(req_write), .rb_n(rb_n),
        .ce_n(ce_n), .re_n(re_n), .we_n(we_n), .cycle_done(cycle_done)
    );

    // Pack fields by the bit positions of R2.
    function automatic logic [31:0] mk(input int ce, input int bd, input int ta,
                                       input int rh, input int rl, input int wh, input int wl);
        return {6'd0, 2'(ce), 5'(bd), 3'(ta), 4'(rh), 4'(rl), 4'(wh), 4'(wl)};
    endfunction

    function automatic int eff(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    // Vector: {write, word, ready-from cycle (0 = always ready), poke cycle (0 = none)}
    localparam logic [48:0] VEC [NVEC] = '{
        {1'b0, mk(0, 0, 0, 0, 0, 0, 0),  8'd0,  8'd0},
        {1'b0, mk(2, 0, 0, 2, 3, 0, 0),  8'd0,  8'd0},
        {1'b1, mk(1, 4, 5, 0, 0, 1, 2),  8'd0,  8'd0},
        {1'b1, mk(0, 0, 7, 0, 0, 0, 0),  8'd9,  8'd3},
        {1'b0, mk(3, 0, 7, 15, 15, 0, 0), 8'd0, 8'd41},
        {1'b1, mk(0, 31, 1, 0, 0, 15, 15), 8'd20, 8'd0},
        {1'b1, mk(0, 2, 0, 0, 0, 1, 1),  8'd40, 8'd0},
        {1'b0, mk(0, 0, 3, 0, 1, 0, 0) | 32'hFC00_0000, 8'd0, 8'd0}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk(ce_n && re_n && we_n && !cycle_done, tag,
            {ce_n, re_n, we_n, cycle_done}, 4'b1110);
    endtask

    // Run one access and measure each phase at the ports.
    task automatic run_vec(input logic wr, input logic [31:0] w, input int k, input int poke);
        int ta, ce, lo, hi, bd, pre, exp_done, p;
        int first_ce, first_st, low_cnt, done_c, done_n;
        bit wrong_st, ce_at_done, idle_bad;
        ta = int'(w[18:16]); ce = int'(w[25:24]); bd = int'(w[23:19]);
        lo = wr ? eff(int'(w[3:0])) : eff(int'(w[11:8]));
        hi = wr ? eff(int'(w[7:4])) : eff(int'(w[15:12]));
        pre = (have_prev && prev_wr != wr) ? ta : 0;
        if (wr) begin
            p = pre + ce + lo + hi + bd + 1;
            exp_done = ((k > p) ? k : p) + 1;
        end else begin
            exp_done = pre + ce + lo + hi + 1;
        end
        first_ce = 0; first_st = 0; low_cnt = 0; done_c = 0; done_n = 0;
        wrong_st = 1'b0; ce_at_done = 1'b0; idle_bad = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; timing_word = w; rb_n = (k == 0);
        for (int c = 1; c < 400; c++) begin
            @(negedge clk);
            req_valid   = (c == poke);
            req_write   = (c == poke) ? !wr : wr;
            timing_word = ~w;
            rb_n        = (k == 0) || (c >= k);
            if (done_c != 0 && c > done_c) begin
                if (!ce_n || !re_n || !we_n || cycle_done) idle_bad = 1'b1;
                if (c >= done_c + 3) break;
            end else begin
                if (!ce_n && first_ce == 0) first_ce = c;
                if (!re_n || !we_n) begin
                    if (first_st == 0) first_st = c;
                    low_cnt++;
                end
                if ((wr && !re_n) || (!wr && !we_n)) wrong_st = 1'b1;
                if (cycle_done) begin
                    done_c = c; done_n++;
                    if (!ce_n) ce_at_done = 1'b1;
                end
            end
        end
        req_valid = 1'b0;
        // R7: turnaround gap with ce_n high
        chk(first_ce - 1 == pre, "R7 gap", first_ce - 1, pre);
        // R3: access begins the cycle after acceptance
        chk(first_ce >= 1, "R3 start", first_ce, 1);
        // R6: chip-enable setup before the strobe
        chk(first_st - first_ce == ce, "R6 setup", first_st - first_ce, ce);
        // R4 and R2: strobe low length from captured fields
        chk(low_cnt == lo, "R4 low", low_cnt, lo);
        chk(!wrong_st, "R4 strobe select", wrong_st, 0);
        // R5, R8, R9: done timing covers high phase, busy delay and ready wait
        chk(done_c == exp_done, wr ? "R8 done" : "R5 done", done_c, exp_done);
        // R9: ce_n high in the done cycle
        chk(!ce_at_done, "R9 ce at done", ce_at_done, 0);
        // R10: no second access after a request during the running one
        chk(!idle_bad, "R10 idle after", idle_bad, 0);
        have_prev = 1'b1;
        prev_wr   = wr;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; timing_word = '0; req_valid = 1'b0; req_write = 1'b0; rb_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check_idle("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R1 idle");

        for (int i = 0; i < NVEC; i++) begin
            run_vec(VEC[i][48], VEC[i][47:16], int'(VEC[i][15:8]), int'(VEC[i][7:0]));
        end

        // R1: reset in the middle of a read clears the outputs and the history
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; timing_word = mk(0, 0, 0, 0, 9, 0, 0);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(!re_n, "R4 read low before reset", re_n, 0);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check_idle("R1 mid reset");
        rst_n = 1'b1;
        have_prev = 1'b0;
        // R7: first write after reset has no gap even though turnaround is 6
        run_vec(1'b1, mk(1, 3, 6, 0, 0, 2, 3), 0, 0);
        // R7: read right after the write takes the gap
        run_vec(1'b0, mk(0, 0, 6, 1, 2, 0, 0), 0, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule